// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block is the command front end of a parallel NOR-style memory for one operation: programming a run of words inside a single page through a write buffer. A host issues bus write cycles, each one an address, a data word and a write enable. Two fixed unlock cycles come first, then a setup command whose address picks the target page. The next cycle gives the number of words minus one. The host then loads that many address/data pairs, and finally writes a confirm command to the same page. The block then holds a busy phase of fixed length and commits the buffered words into a small behavioural array.

Reads return array contents in read mode. While programming runs, and after an abort or a failure, reads return a status word instead. A broken sequence aborts the operation: an address outside the page, an oversized count, or a wrong command where confirm is due. An attempt to turn a stored 0 into a 1 is reported as a program failure. A reset command leaves either error state.

Top module: `fbp_seq`

## Requirements
- R1: After reset the array holds all-ones in every word, `busy` is low and reads return array data.
- R2: A setup is accepted only after a write of 0xAA to address 0x555 followed directly by 0x55 to 0x2AA. The setup is data 0x25, and its address selects the page (address bits above the page offset). Any other write in place of an unlock cycle or the setup returns to read mode, and the array is left unchanged.
- R3: The cycle after setup carries the word count minus one. It must address the chosen page and be below the page size (16 words), or the operation aborts.
- R4: Every load must address the chosen page. A load outside the page aborts the operation, and nothing is programmed.
- R5: Each load consumes one unit of the count, including loads to a repeated address. Once the count is used up, the next write must be 0x29 addressed to the page, or the operation aborts.
- R6: When an address is loaded more than once, the last data loaded for it is programmed.
- R7: `busy` rises on the cycle after an accepted confirm and stays high for exactly PROG_CYCLES cycles (8). Writes during that time are ignored.
- R8: A read takes effect one cycle after `rd_en`, and `rd_data` holds its value until the next read. While busy, aborted or failed, a read returns a status word. Bit 7 is the inverse of bit 7 of the last loaded word. Bit 6 flips on every status read. Bit 5 flags a program failure and bit 1 flags an abort. All other bits are 0.
- R9: If any loaded word has a 1 where the array word holds 0, the operation ends in the failure state (status bit 5). Each loaded word is stored as the AND of the old word and the new word.
- R10: In the abort or failure state, only a write of data 0xF0 is acted on, and it returns to read mode. Other writes leave the status unchanged.
- R11: Words of the page that were not loaded keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W (12) | Bus write address |
| wr_data | input | DATA_W (8) | Bus write data or command |
| rd_en | input | 1 | Read request |
| rd_addr | input | MEM_W (8) | Array word address for reads |
| rd_data | output | DATA_W (8) | Array word or status, registered |
| busy | output | 1 | Programming phase in progress |

## Verification
A sequencer stuck in the wrong state shows at the ports on the next read. Reads return status where array data is due, or the reverse, and the abort or failure flag is wrong. A count register that is off by one turns a correct confirm into an abort, which shows in bit 1 of the next status read. It can also let the busy phase start a cycle early or late, which `busy` exposes in the cycle itself. A buffer or commit error reaches the ports only when the affected words are read back after programming. The bench therefore reads every loaded word, including repeated and skipped ones.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [3:0] {
      ST_READ,
      ST_UNLK1,
      ST_UNLK2,
      ST_COUNT,
      ST_LOAD,
      ST_CONFIRM,
      ST_PROG,
      ST_ABORT,
      ST_FAIL
   } fbp_state_e;

   localparam logic [11:0] UNLK_ADDR_A = 12'h555;
   localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
   localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
   localparam logic [7:0]  UNLK_DATA_B = 8'h55;
   localparam logic [7:0]  CMD_SETUP   = 8'h25;
   localparam logic [7:0]  CMD_CONFIRM = 8'h29;
   localparam logic [7:0]  CMD_RESET   = 8'hF0;
endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic                                 ld,
   input  logic [PAGE_W-1:0]                    ld_off,
   input  logic [DATA_W-1:0]                    ld_data,
   output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]   slot_data,
   output logic [(1<<PAGE_W)-1:0]               slot_vld
);
   localparam int PAGE_WORDS = 1 << PAGE_W;

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
      logic              v_q;
      logic [DATA_W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (ld && ld_off == PAGE_W'(i)) begin
            v_q <= 1'b1;
            d_q <= ld_data;
         end
      end

      assign slot_vld[i]  = v_q;
      assign slot_data[i] = d_q;
   end
endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
   parameter int MEM_W  = 8,
   parameter int PAGE_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 commit,
   input  logic [MEM_W-PAGE_W-1:0]              page_base,
   input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]   slot_data,
   input  logic [(1<<PAGE_W)-1:0]               slot_vld,
   input  logic [MEM_W-1:0]                     rd_idx,
   output logic [DATA_W-1:0]                    rd_word,
   output logic                                 fail
);
   localparam int PAGE_WORDS = 1 << PAGE_W;
   localparam int DEPTH      = 1 << MEM_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
      end else if (commit) begin
         for (int i = 0; i < PAGE_WORDS; i++) begin
            if (slot_vld[i])
               mem[{page_base, PAGE_W'(i)}] <= mem[{page_base, PAGE_W'(i)}] & slot_data[i];
         end
      end
   end

   // a loaded 1 over a stored 0 cannot be programmed
   always_comb begin
      fail = 1'b0;
      for (int i = 0; i < PAGE_WORDS; i++) begin
         if (slot_vld[i] && |(slot_data[i] & ~mem[{page_base, PAGE_W'(i)}]))
            fail = 1'b1;
      end
   end

   assign rd_word = mem[rd_idx];
endmodule

// File: rtl/fbp_status.sv
module fbp_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              stat_mode,
   input  logic              last_msb,
   input  logic              is_fail,
   input  logic              is_abort,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] rd_data
);
   logic              tog_q;
   logic [DATA_W-1:0] stat_word;

   always_comb begin
      stat_word    = '0;
      stat_word[7] = ~last_msb;
      stat_word[6] = tog_q;
      stat_word[5] = is_fail;
      stat_word[1] = is_abort;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q   <= 1'b0;
         rd_data <= '0;
      end else if (rd_en) begin
         if (stat_mode) begin
            rd_data <= stat_word;
            tog_q   <= ~tog_q;
         end else begin
            rd_data <= arr_word;
         end
      end
   end
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
   import fbp_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int MEM_W       = 8,
   parameter int PAGE_W      = 4,
   parameter int DATA_W      = 8,
   parameter int PROG_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [MEM_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   localparam int PAGE_WORDS = 1 << PAGE_W;
   localparam int PG_W       = ADDR_W - PAGE_W;
   localparam int CNT_W      = PAGE_W + 1;
   localparam int TMR_W      = $clog2(PROG_CYCLES);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must hold the unlock addresses");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command");
   end
   if (PAGE_W < 1 || PAGE_W >= MEM_W || MEM_W > ADDR_W || PAGE_W >= 8) begin : g_bad_page
      $error("page, array and address widths are inconsistent");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end

   fbp_state_e        st;
   logic [PG_W-1:0]   page;
   logic [CNT_W-1:0]  cnt;
   logic [TMR_W-1:0]  timer;
   logic              last_msb;

   logic              in_page, buf_ld, buf_clr, commit, prog_fail, stat_mode;
   logic [7:0]        cmd;
   logic [DATA_W-1:0] arr_word;
   logic [PAGE_WORDS-1:0][DATA_W-1:0] slot_data;
   logic [PAGE_WORDS-1:0]             slot_vld;

   assign cmd       = wr_data[7:0];
   assign in_page   = (wr_addr[ADDR_W-1:PAGE_W] == page);
   assign buf_ld    = wr_en && (st == ST_LOAD) && in_page;
   assign buf_clr   = wr_en && (st == ST_UNLK2) && (cmd == CMD_SETUP);
   assign commit    = (st == ST_PROG) && (timer == '0);
   assign stat_mode = (st == ST_PROG) || (st == ST_ABORT) || (st == ST_FAIL);
   assign busy      = (st == ST_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_READ;
         page     <= '0;
         cnt      <= '0;
         timer    <= '0;
         last_msb <= 1'b0;
      end else begin
         case (st)
            ST_READ: begin
               if (wr_en && wr_addr[11:0] == UNLK_ADDR_A && cmd == UNLK_DATA_A)
                  st <= ST_UNLK1;
            end
            ST_UNLK1: begin
               if (wr_en)
                  st <= (wr_addr[11:0] == UNLK_ADDR_B && cmd == UNLK_DATA_B) ? ST_UNLK2 : ST_READ;
            end
            ST_UNLK2: begin
               if (wr_en) begin
                  if (cmd == CMD_SETUP) begin
                     page <= wr_addr[ADDR_W-1:PAGE_W];
                     st   <= ST_COUNT;
                  end else begin
                     st <= ST_READ;
                  end
               end
            end
            ST_COUNT: begin
               if (wr_en) begin
                  if (in_page && wr_data < DATA_W'(PAGE_WORDS)) begin
                     cnt <= {1'b0, wr_data[PAGE_W-1:0]} + CNT_W'(1);
                     st  <= ST_LOAD;
                  end else begin
                     st <= ST_ABORT;
                  end
               end
            end
            ST_LOAD: begin
               if (wr_en) begin
                  if (in_page) begin
                     cnt      <= cnt - CNT_W'(1);
                     last_msb <= wr_data[7];
                     if (cnt == CNT_W'(1)) st <= ST_CONFIRM;
                  end else begin
                     st <= ST_ABORT;
                  end
               end
            end
            ST_CONFIRM: begin
               if (wr_en) begin
                  if (in_page && cmd == CMD_CONFIRM) begin
                     timer <= TMR_W'(PROG_CYCLES - 1);
                     st    <= ST_PROG;
                  end else begin
                     st <= ST_ABORT;
                  end
               end
            end
            ST_PROG: begin
               if (timer == '0) st <= prog_fail ? ST_FAIL : ST_READ;
               else             timer <= timer - TMR_W'(1);
            end
            ST_ABORT, ST_FAIL: begin
               if (wr_en && cmd == CMD_RESET) st <= ST_READ;
            end
            default: st <= ST_READ;
         endcase
      end
   end

   fbp_wbuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .ld        (buf_ld),
      .ld_off    (wr_addr[PAGE_W-1:0]),
      .ld_data   (wr_data),
      .slot_data (slot_data),
      .slot_vld  (slot_vld)
   );

   fbp_array #(.MEM_W(MEM_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .page_base (page[MEM_W-PAGE_W-1:0]),
      .slot_data (slot_data),
      .slot_vld  (slot_vld),
      .rd_idx    (rd_addr),
      .rd_word   (arr_word),
      .fail      (prog_fail)
   );

   fbp_status #(.DATA_W(DATA_W)) i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .stat_mode (stat_mode),
      .last_msb  (last_msb),
      .is_fail   (st == ST_FAIL),
      .is_abort  (st == ST_ABORT),
      .arr_word  (arr_word),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk
   import fbp_pkg::*;
#(
   parameter int PAGE_W      = 4,
   parameter int PROG_CYCLES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       cmd,
   input logic             rd_en,
   input logic [2:0]       rd_dq,
   input logic             busy,
   input fbp_state_e       st,
   input logic [PAGE_W:0]  cnt
);
   localparam int BW = $clog2(PROG_CYCLES + 1);

   logic [BW-1:0] busy_len;
   logic          smode;

   assign smode = (st == ST_PROG) || (st == ST_ABORT) || (st == ST_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= '0;
      else if (!busy) busy_len <= '0;
      else            busy_len <= busy_len + BW'(1);
   end

   assert_busy_from_confirm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wr_en) && $past(cmd) == CMD_CONFIRM));

   assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < BW'(PROG_CYCLES)));

   assert_abort_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_ABORT) |-> $past(wr_en));

   assert_confirm_count_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONFIRM) |-> (cnt == '0));

   assert_error_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st == ST_ABORT || st == ST_FAIL) |-> ($past(wr_en) && $past(cmd) == CMD_RESET));

   assert_busy_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && busy) |-> (rd_dq[1:0] == 2'b00));

   assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_en && smode) && $past(rd_en && smode, 2)) |-> (rd_dq[2] != $past(rd_dq[2])));
endmodule

bind fbp_seq fbp_seq_chk #(.PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) i_fbp_seq_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .cmd   (wr_data[7:0]),
   .rd_en (rd_en),
   .rd_dq ({rd_data[6], rd_data[5], rd_data[1]}),
   .busy  (busy),
   .st    (st),
   .cnt   (cnt)
);

// File: tb/test_fbp_seq.sv
`timescale 1ns/1ps
module test_fbp_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fbp_seq i_fbp_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   // behavioural reference: 0 read,1 unlk1,2 unlk2,3 count,4 load,5 confirm,6 prog,7 abort,8 fail
   int         mst, mpage, mcnt, mbusy;
   logic [7:0] mmem [256];
   logic [7:0] mbuf [16];
   bit         mvld [16];
   bit         mlast, mtog;
   logic [7:0] mexp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst = 0; mpage = 0; mcnt = 0; mbusy = 0; mlast = 0; mtog = 0; mexp = 8'h00;
         for (int k = 0; k < 256; k++) mmem[k] = 8'hFF;
         for (int k = 0; k < 16; k++) begin mvld[k] = 0; mbuf[k] = 8'h00; end
      end else begin
         if (rd_en) begin
            if (mst >= 6) begin
               mexp = 8'h00;
               mexp[7] = ~mlast;
               mexp[6] = mtog;
               mexp[5] = (mst == 8);
               mexp[1] = (mst == 7);
               mtog = ~mtog;
            end else begin
               mexp = mmem[rd_addr];
            end
         end
         case (mst)
            0: if (wr_en && wr_addr == 12'h555 && wr_data == 8'hAA) mst = 1;
            1: if (wr_en) mst = (wr_addr == 12'h2AA && wr_data == 8'h55) ? 2 : 0;
            2: if (wr_en) begin
                  if (wr_data == 8'h25) begin
                     mst = 3; mpage = int'(wr_addr) >> 4;
                     for (int k = 0; k < 16; k++) mvld[k] = 0;
                  end else mst = 0;
               end
            3: if (wr_en) begin
                  if ((int'(wr_addr) >> 4) == mpage && wr_data < 16) begin
                     mcnt = int'(wr_data) + 1; mst = 4;
                  end else mst = 7;
               end
            4: if (wr_en) begin
                  if ((int'(wr_addr) >> 4) == mpage) begin
                     mbuf[int'(wr_addr) & 15] = wr_data;
                     mvld[int'(wr_addr) & 15] = 1;
                     mlast = wr_data[7];
                     mcnt = mcnt - 1;
                     if (mcnt == 0) mst = 5;
                  end else mst = 7;
               end
            5: if (wr_en) begin
                  if ((int'(wr_addr) >> 4) == mpage && wr_data == 8'h29) begin
                     mst = 6; mbusy = 8;
                  end else mst = 7;
               end
            6: begin
                  mbusy = mbusy - 1;
                  if (mbusy == 0) begin
                     bit f;
                     int base;
                     f = 0;
                     base = (mpage & 15) * 16;
                     for (int k = 0; k < 16; k++)
                        if (mvld[k] && ((mbuf[k] & ~mmem[base + k]) != 8'h00)) f = 1;
                     for (int k = 0; k < 16; k++)
                        if (mvld[k]) mmem[base + k] = mmem[base + k] & mbuf[k];
                     mst = f ? 8 : 0;
                  end
               end
            default: if (wr_en && wr_data == 8'hF0) mst = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare against the reference model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rd_data == mexp, "R8 read data vs model", rd_data, mexp);
         chk(busy == (mst == 6), "R7 busy vs model", busy, (mst == 6));
      end
   end

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] v);
      @(negedge clk); rd_en = 1'b1; rd_addr = a[7:0];
      @(negedge clk); rd_en = 1'b0; v = rd_data;
   endtask

   task automatic start_op(input logic [11:0] a);
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
      wr(a, 8'h25);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v, v2;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(12'h000, v); chk(v == 8'hFF, "R1 erased word 0x00", v, 8'hFF);
      rd(12'h0FF, v); chk(v == 8'hFF, "R1 erased word 0xFF", v, 8'hFF);
      chk(busy == 1'b0, "R1 busy low", busy, 0);

      // normal program with a repeated address (R5, R6, R7, R11)
      start_op(12'h130);
      wr(12'h130, 8'h03);
      wr(12'h131, 8'h3C);
      wr(12'h132, 8'hA5);
      wr(12'h131, 8'h0F);
      wr(12'h13F, 8'h70);
      wr(12'h130, 8'h29);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == 8, "R7 busy length", n, 8);
      rd(12'h131, v); chk(v == 8'h0F, "R6 last load wins", v, 8'h0F);
      rd(12'h132, v); chk(v == 8'hA5, "R5 word programmed", v, 8'hA5);
      rd(12'h13F, v); chk(v == 8'h70, "R5 word programmed", v, 8'h70);
      rd(12'h130, v); chk(v == 8'hFF, "R11 unloaded word kept", v, 8'hFF);
      rd(12'h133, v); chk(v == 8'hFF, "R11 unloaded word kept", v, 8'hFF);

      // status while busy, write ignored during busy (R7, R8)
      start_op(12'h140);
      wr(12'h145, 8'h00);
      wr(12'h145, 8'h12);
      wr(12'h145, 8'h29);
      rd(12'h000, v);
      rd(12'h000, v2);
      chk(v[7] == 1'b1, "R8 bit7 inverse of last msb", v[7], 1);
      chk(v[6] != v2[6], "R8 bit6 toggles", v2[6], ~v[6]);
      chk({v[5], v[1]} == 2'b00, "R8 no flags while busy", {v[5], v[1]}, 0);
      wr(12'h145, 8'hF0);
      chk(busy == 1'b1, "R7 write during busy ignored", busy, 1);
      wait_idle();
      rd(12'h145, v); chk(v == 8'h12, "R7 programmed after busy", v, 8'h12);

      // load outside the page (R4, R10)
      start_op(12'h200);
      wr(12'h200, 8'h01);
      wr(12'h203, 8'h00);
      wr(12'h213, 8'h00);
      rd(12'h003, v); chk(v[1] == 1'b1 && v[5] == 1'b0, "R4 abort flag", v, 8'h02);
      wr(12'h203, 8'h55);
      rd(12'h003, v); chk(v[1] == 1'b1, "R10 other write ignored in abort", v[1], 1);
      wr(12'h000, 8'hF0);
      rd(12'h003, v); chk(v == 8'hFF, "R10 back to read mode, R4 nothing programmed", v, 8'hFF);

      // oversized count (R3)
      start_op(12'h300);
      wr(12'h300, 8'h10);
      rd(12'h000, v); chk(v[1] == 1'b1, "R3 count too large aborts", v[1], 1);
      wr(12'h000, 8'hF0);

      // legal count of 16 words is accepted (R3)
      start_op(12'h300);
      wr(12'h300, 8'h0F);
      rd(12'h000, v); chk(v == 8'hFF, "R3 count 16 accepted, still read mode", v, 8'hFF);
      wr(12'h210, 8'h00);
      wr(12'h000, 8'hF0);

      // missing confirm (R5)
      start_op(12'h310);
      wr(12'h310, 8'h00);
      wr(12'h311, 8'h00);
      wr(12'h312, 8'h00);
      rd(12'h011, v); chk(v[1] == 1'b1, "R5 extra load aborts", v[1], 1);
      wr(12'h000, 8'hF0);
      rd(12'h011, v); chk(v == 8'hFF, "R5 aborted op not programmed", v, 8'hFF);

      // broken unlock (R2)
      wr(12'h555, 8'hAA);
      wr(12'h2AB, 8'h55);
      wr(12'h130, 8'h25);
      wr(12'h130, 8'h00);
      wr(12'h131, 8'h00);
      wr(12'h130, 8'h29);
      chk(busy == 1'b0, "R2 no operation after bad unlock", busy, 0);
      rd(12'h131, v); chk(v == 8'h0F, "R2 array unchanged", v, 8'h0F);

      // 0 to 1 attempt (R9)
      start_op(12'h130);
      wr(12'h130, 8'h00);
      wr(12'h131, 8'hF3);
      wr(12'h131, 8'h29);
      wait_idle();
      rd(12'h000, v);
      chk(v[5] == 1'b1 && v[1] == 1'b0, "R9 fail flag", v, 8'h20);
      chk(v[7] == 1'b0, "R9 bit7 inverse of last msb", v[7], 0);
      wr(12'h000, 8'hF0);
      rd(12'h131, v); chk(v == 8'h03, "R9 stored AND of old and new", v, 8'h03);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule